// File: doc/BRIEF.md
# Serial Command Register

This block takes 16-bit command words from a three-wire serial port (enable, serial clock, serial data) and keeps the sensor's runtime settings: a 10-bit gain code, a 10-bit shutter code, a frame-rate mode bit and a clamp mode bit. All three port lines are asynchronous to the master clock. They pass through synchronizers, and the serial clock's rising edges are detected in the master clock domain, so the serial clock must run at no more than a quarter of the master clock.

The host drives enable low, sends the bits least significant first with one bit per serial clock rising edge, then drives enable high. The rising edge of enable commits the last sixteen bits received. The upper nibble selects the target register, and the ten bits D11..D2 carry the value. The outputs feed the timing and gain stages directly.

Top module: `serial_cmd_reg`

## Requirements
- R1: After reset, and before any command, gain_o equals GAIN_RST (default 192), shutter_o equals SHUT_RST (default 0), and monitor_o and clamp_man_o are 0.
- R2: Bits are taken on serial clock rising edges while enable is low. The first bit sent is D0 and the sixteenth is D15.
- R3: A committed word with D15..D12 = 4'b0000 loads gain_o with D11..D2. D11 is the MSB.
- R4: A committed word with D15..D12 = 4'b0001 loads shutter_o with D11..D2.
- R5: A committed word with D15..D12 = 4'b1111 loads monitor_o from D2 (0 = 30 fps, 1 = 60 fps) and clamp_man_o from D3 (0 = automatic, 1 = manual/off).
- R6: A word with any other value in D15..D12 leaves all four outputs unchanged.
- R7: When more than sixteen serial clock edges occur in one enable-low window, only the last sixteen bits form the word.
- R8: A window with fewer than sixteen serial clock edges commits nothing.
- R9: The edge count restarts in every window. Two short windows separated by enable high commit nothing, even when together they hold sixteen or more edges.
- R10: A committed value appears on the outputs at the third master clock rising edge after enable is driven high, and not at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Serial enable; a rising edge commits the word |
| sclk_i | input | 1 | Serial clock; data taken on its rising edge |
| sdata_i | input | 1 | Serial data, D0 first |
| gain_o | output | 10 | Gain code |
| shutter_o | output | 10 | Shutter code |
| monitor_o | output | 1 | Frame-rate mode, 1 = 60 fps |
| clamp_man_o | output | 1 | Clamp mode, 1 = manual/off |

## Verification
A fault in the shift chain or the field slicing shows as a wrong gain or shutter code three master clocks after the commit. Gain and shutter values are swept across the whole field, so every bit position is covered. A wrong edge count shows up in two ways: short windows that update the outputs, or long windows whose leading junk leaks into the value. The decode is tested with all sixteen selector codes, so a selector fault changes an output that should have held. The latency check looks at the second and third edges after enable rises, so one extra or one missing synchronizer stage is caught.

// File: rtl/serial_cmd_pkg.sv
`timescale 1ns/1ps
package serial_cmd_pkg;
  localparam int CMD_W     = 16;
  localparam int FIELD_LSB = 2;
  localparam int FIELD_W   = 10;
  localparam int SEL_W     = CMD_W - FIELD_LSB - FIELD_W;
  // only D15..D2 are kept; D1..D0 fall off the end of the shifter
  localparam int KEEP_W    = CMD_W - FIELD_LSB;
  localparam int CNT_W     = $clog2(CMD_W + 1);

  typedef enum logic [SEL_W-1:0] {
    SEL_GAIN = 4'b0000,
    SEL_SHUT = 4'b0001,
    SEL_MODE = 4'b1111
  } sel_e;
endpackage

// File: rtl/serial_cmd_sync.sv
`timescale 1ns/1ps
module serial_cmd_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/serial_cmd_capture.sv
`timescale 1ns/1ps
module serial_cmd_capture
  import serial_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_s_i,
  input  logic              sclk_s_i,
  input  logic              sdata_s_i,
  output logic              apply_o,
  output logic [KEEP_W-1:0] word_o
);
  logic             en_q, sclk_q;
  logic             sclk_rise, en_rise;
  logic [CNT_W-1:0] cnt_q;
  logic [KEEP_W-1:0] sh_q;

  assign sclk_rise = sclk_s_i & ~sclk_q;
  assign en_rise   = en_s_i & ~en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      en_q   <= en_s_i;
      sclk_q <= sclk_s_i;
    end
  end

  // edge count saturates at one word, cleared while enable is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (en_s_i) cnt_q <= '0;
    else if (sclk_rise && (cnt_q != CNT_W'(CMD_W))) cnt_q <= cnt_q + 1'b1;
  end

  // LSB-first: newest bit enters at the top
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else if (!en_s_i && sclk_rise) sh_q <= {sdata_s_i, sh_q[KEEP_W-1:1]};
  end

  assign apply_o = en_rise && (cnt_q == CNT_W'(CMD_W));
  assign word_o  = sh_q;
endmodule

// File: rtl/serial_cmd_regs.sv
`timescale 1ns/1ps
module serial_cmd_regs
  import serial_cmd_pkg::*;
#(
  parameter logic [FIELD_W-1:0] GAIN_RST = 10'd192,
  parameter logic [FIELD_W-1:0] SHUT_RST = 10'd0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               apply_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic [FIELD_W-1:0] gain_o,
  output logic [FIELD_W-1:0] shutter_o,
  output logic               monitor_o,
  output logic               clamp_man_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_o      <= GAIN_RST;
      shutter_o   <= SHUT_RST;
      monitor_o   <= 1'b0;
      clamp_man_o <= 1'b0;
    end else if (apply_i) begin
      unique case (sel_i)
        SEL_GAIN: gain_o    <= field_i;
        SEL_SHUT: shutter_o <= field_i;
        SEL_MODE: begin
          monitor_o   <= field_i[0];
          clamp_man_o <= field_i[1];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/serial_cmd_reg.sv
`timescale 1ns/1ps
module serial_cmd_reg
  import serial_cmd_pkg::*;
#(
  parameter int                 SYNC_STAGES = 2,
  parameter logic [FIELD_W-1:0] GAIN_RST    = 10'd192,
  parameter logic [FIELD_W-1:0] SHUT_RST    = 10'd0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               sclk_i,
  input  logic               sdata_i,
  output logic [FIELD_W-1:0] gain_o,
  output logic [FIELD_W-1:0] shutter_o,
  output logic               monitor_o,
  output logic               clamp_man_o
);
  logic [2:0]        pins_s;
  logic              apply;
  logic [KEEP_W-1:0] word;

  serial_cmd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({en_i, sclk_i, sdata_i}),
    .q_o    (pins_s)
  );

  serial_cmd_capture u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_s_i    (pins_s[2]),
    .sclk_s_i  (pins_s[1]),
    .sdata_s_i (pins_s[0]),
    .apply_o   (apply),
    .word_o    (word)
  );

  serial_cmd_regs #(.GAIN_RST(GAIN_RST), .SHUT_RST(SHUT_RST)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .apply_i     (apply),
    .sel_i       (word[KEEP_W-1 -: SEL_W]),
    .field_i     (word[FIELD_W-1:0]),
    .gain_o      (gain_o),
    .shutter_o   (shutter_o),
    .monitor_o   (monitor_o),
    .clamp_man_o (clamp_man_o)
  );
endmodule

// File: rtl/serial_cmd_reg_chk.sv
`timescale 1ns/1ps
module serial_cmd_reg_chk
  import serial_cmd_pkg::*;
#(
  parameter logic [FIELD_W-1:0] GAIN_RST = 10'd192,
  parameter logic [FIELD_W-1:0] SHUT_RST = 10'd0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               apply_i,
  input logic [KEEP_W-1:0]  word_i,
  input logic [FIELD_W-1:0] gain_o,
  input logic [FIELD_W-1:0] shutter_o,
  input logic               monitor_o,
  input logic               clamp_man_o
);
  logic [SEL_W-1:0] sel;
  assign sel = word_i[KEEP_W-1 -: SEL_W];

  a_r1_reset_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (gain_o == GAIN_RST && shutter_o == SHUT_RST && !monitor_o && !clamp_man_o));

  a_r3_gain_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply_i && sel == SEL_GAIN) |=> gain_o == $past(word_i[FIELD_W-1:0]));

  a_r4_shutter_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply_i && sel == SEL_SHUT) |=> shutter_o == $past(word_i[FIELD_W-1:0]));

  a_r5_mode_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply_i && sel == SEL_MODE) |=> (monitor_o == $past(word_i[0]) && clamp_man_o == $past(word_i[1])));

  a_r6_unknown_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply_i && sel != SEL_GAIN && sel != SEL_SHUT && sel != SEL_MODE)
    |=> ($stable(gain_o) && $stable(shutter_o) && $stable(monitor_o) && $stable(clamp_man_o)));

  a_r8_hold_without_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> ($stable(gain_o) && $stable(shutter_o) && $stable(monitor_o) && $stable(clamp_man_o)));
endmodule

bind serial_cmd_reg serial_cmd_reg_chk #(.GAIN_RST(GAIN_RST), .SHUT_RST(SHUT_RST)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .apply_i     (apply),
  .word_i      (word),
  .gain_o      (gain_o),
  .shutter_o   (shutter_o),
  .monitor_o   (monitor_o),
  .clamp_man_o (clamp_man_o)
);

// File: tb/serial_cmd_reg_tb.sv
`timescale 1ns/1ps
module serial_cmd_reg_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b1, sclk = 1'b0, sdata = 1'b0;
  logic [9:0] gain, shutter;
  logic monitor, clamp;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [9:0] e_gain = 10'd192, e_shut = 10'd0;
  logic e_mon = 1'b0, e_clamp = 1'b0;

  always #2.5 clk = ~clk;

  serial_cmd_reg u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .sclk_i(sclk), .sdata_i(sdata),
    .gain_o(gain), .shutter_o(shutter), .monitor_o(monitor), .clamp_man_o(clamp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, {22'd0, gain}, {22'd0, e_gain});
    chk(req, {22'd0, shutter}, {22'd0, e_shut});
    chk(req, {30'd0, clamp, monitor}, {30'd0, e_clamp, e_mon});
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // n bits; the last 16 are w, D0 first; earlier bits are junk
  task automatic window(input logic [15:0] w, input int n, input logic [15:0] junk);
    en = 1'b0;
    waitn(4);
    for (int i = 0; i < n; i++) begin
      sdata = (i < n - 16) ? junk[i % 16] : w[i - (n - 16)];
      waitn(4);
      sclk = 1'b1;
      waitn(4);
      sclk = 1'b0;
    end
    waitn(2);
  endtask

  task automatic send(input logic [15:0] w, input int n);
    window(w, n, 16'hA5C3);
    en = 1'b1;
    waitn(6);
  endtask

  function automatic logic [15:0] mk(input logic [3:0] sel, input logic [9:0] v, input logic [1:0] lo);
    return {sel, v, lo};
  endfunction

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    waitn(3);
    check_all("R1");
    rst_ni = 1'b1;
    waitn(3);
    check_all("R1");

    // R3, R2: gain sweep covers every field bit
    for (int v = 0; v < 1024; v += 5) begin
      send(mk(4'h0, v[9:0], v[1:0]), 16);
      e_gain = v[9:0];
      chk("R3", {22'd0, gain}, {22'd0, e_gain});
    end
    send(mk(4'h0, 10'h3FF, 2'b11), 16); e_gain = 10'h3FF; check_all("R2");
    // R4 shutter sweep
    for (int v = 1023; v >= 0; v -= 7) begin
      send(mk(4'h1, v[9:0], ~v[1:0]), 16);
      e_shut = v[9:0];
      chk("R4", {22'd0, shutter}, {22'd0, e_shut});
    end
    // R5 all mode combinations
    for (int m = 0; m < 4; m++) begin
      send(mk(4'hF, {8'hAA, m[1:0]}, 2'b01), 16);
      e_mon = m[0]; e_clamp = m[1];
      check_all("R5");
    end
    // R6 every other selector ignored
    for (int s = 2; s < 15; s++) begin
      send(mk(s[3:0], 10'h155, 2'b10), 16);
      check_all("R6");
    end
    // R7 long windows keep last 16 bits
    for (int n = 17; n <= 40; n += 3) begin
      send(mk(4'h0, 10'(n * 13), 2'b00), n);
      e_gain = 10'(n * 13);
      check_all("R7");
    end
    // R8 short windows commit nothing
    for (int n = 1; n < 16; n++) begin
      send(mk(4'h1, 10'h2AA, 2'b00), n);
      check_all("R8");
    end
    // R9 count restarts per window
    window(16'hFFFF, 10, 16'h0);
    en = 1'b1; waitn(6);
    window(mk(4'h0, 10'h0F0, 2'b00), 10, 16'hFFFF);
    en = 1'b1; waitn(6);
    check_all("R9");
    // R10 latency: old value after 2 edges, new after 3
    window(mk(4'h0, 10'h123, 2'b00), 16, 16'h0);
    en = 1'b1;
    waitn(2);
    chk("R10", {22'd0, gain}, {22'd0, e_gain});
    waitn(1);
    e_gain = 10'h123;
    chk("R10", {22'd0, gain}, {22'd0, e_gain});
    waitn(4);
    // R1 reset mid-run restores defaults
    rst_ni = 1'b0;
    e_gain = 10'd192; e_shut = 10'd0; e_mon = 1'b0; e_clamp = 1'b0;
    waitn(2);
    check_all("R1");
    rst_ni = 1'b1;
    waitn(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule